// File: doc/BRIEF.md
# Overcurrent Hiccup Supervisor

This block turns a first-level overcurrent flag into a timed hiccup sequence for a resonant power stage controller. A saturating digital accumulator takes the place of a delay capacitor. On each tick it charges by a fixed step while overcurrent is present, and otherwise it bleeds away slowly. Three thresholds on that one accumulator move the block through four phases: normal, forced maximum frequency, stopped, and restart.

The outputs are flags for the surrounding controller. One asks for the soft-start network to be discharged. One pins the oscillator at its maximum frequency. One halts switching, and one asks the power-factor pre-regulator to shut down. A brief overload leaves charge in the accumulator, so a second overload that follows soon after trips earlier. The accumulator also keeps its value through an undervoltage-lockout event, which means switching cannot resume early after the supply comes back.

Top module: `hiccup_supervisor`

## Requirements
- R1: After reset the accumulator is zero, the phase is normal and all four outputs are low.
- R2: On each cycle with `tick_i` high and charging enabled, the accumulator grows by `CHG_STEP` and saturates at full scale. With `tick_i` low it does not change. In normal phase `ss_dis_o` is high in the same cycle as `oc_i`.
- R3: Once `oc_i` has been seen, `ss_dis_o` stays high after `oc_i` drops, until a clock edge with `oc_rel_i` high and `oc_i` low.
- R4: In every phase except stopped, the accumulator decays by one LSB per `DECAY_DIV` non-charging ticks and stops at zero. Any charging tick restarts the decay count.
- R5: One clock after the accumulator is at or above `TH_FMAX` = 20*UNIT, the block is in the forced phase: `force_max_o`, `ss_dis_o` and `pfc_stop_o` are high, and the accumulator charges on every tick whatever `oc_i` does.
- R6: One clock after the accumulator is at or above `TH_STOP` = 35*UNIT, the block is in the stopped phase: `stop_o` is high, `force_max_o` is low, charging is off, and decay runs at one LSB per `STOP_DIV` ticks. In this phase `oc_i` has no effect on the accumulator.
- R7: The stopped phase ends only one clock after the accumulator is below `TH_RST` = 3*UNIT. The block then spends one cycle in the restart phase (`stop_o` low, `ss_dis_o` high) and returns to normal.
- R8: `pfc_stop_o` is high throughout the forced and stopped phases and low from the restart phase on.
- R9: While `uv_i` is high, `stop_o` and `ss_dis_o` are high, `pfc_stop_o` and `force_max_o` are low, and nothing charges. The accumulator keeps its value. If it is at or above `TH_RST`, the block stays stopped after `uv_i` falls, until decay brings it below `TH_RST`.
- R10: Residual charge from an earlier short overload shortens the time to the forced phase by exactly the charge that is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timing tick that enables charge and decay |
| oc_i | input | 1 | First-level overcurrent flag |
| oc_rel_i | input | 1 | Sensed current is below the release (hysteresis) level |
| uv_i | input | 1 | Supply undervoltage lockout active |
| ss_dis_o | output | 1 | Soft-start discharge request |
| force_max_o | output | 1 | Hold the oscillator at maximum frequency |
| stop_o | output | 1 | Halt switching |
| pfc_stop_o | output | 1 | Request shutdown of the PFC pre-regulator |

## Verification
The accumulator updates on the tick edge and the phase register follows one clock later. A threshold crossing reached on edge k therefore appears on `force_max_o`, `stop_o` or `pfc_stop_o` after edge k+1. `ss_dis_o` follows `oc_i` and `uv_i` in the same cycle, and its hold clears on the edge that sees the release. The bench works out each expected edge number from the step size, the decay divisors and the thresholds. It counts edges exactly, samples 2 ns after the edge, and checks the output both on the edge before the transition and on the edge of the transition, so that an error of one cycle either way is caught.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    PH_NORMAL  = 2'd0,
    PH_FORCE   = 2'd1,
    PH_STOP    = 2'd2,
    PH_RESTART = 2'd3
  } phase_e;
endpackage

// File: rtl/hiccup_acc.sv
module hiccup_acc #(
  parameter int ACC_W     = 10,
  parameter int CHG_STEP  = 4,
  parameter int DECAY_DIV = 64,
  parameter int STOP_DIV  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             charge_i,
  input  logic             stop_rate_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int DIV_MAX = (DECAY_DIV > STOP_DIV) ? DECAY_DIV : STOP_DIV;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);
  localparam logic [ACC_W-1:0] ACC_MAX  = {ACC_W{1'b1}};
  localparam logic [ACC_W:0]   STEP_X   = (ACC_W+1)'(CHG_STEP);
  localparam logic [DIV_W-1:0] DECAY_LIM = DIV_W'(DECAY_DIV - 1);
  localparam logic [DIV_W-1:0] STOP_LIM  = DIV_W'(STOP_DIV - 1);

  logic [ACC_W-1:0] acc_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic [ACC_W:0]   sum;

  generate
    if (DECAY_DIV == STOP_DIV) begin : g_one_rate
      assign lim = DECAY_LIM;
    end else begin : g_two_rate
      assign lim = stop_rate_i ? STOP_LIM : DECAY_LIM;
    end
  endgenerate

  assign sum = {1'b0, acc_q} + STEP_X;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      div_q <= '0;
    end else if (tick_i) begin
      if (charge_i) begin
        acc_q <= (sum > {1'b0, ACC_MAX}) ? ACC_MAX : sum[ACC_W-1:0];
        div_q <= '0;
      end else if (div_q >= lim) begin
        div_q <= '0;
        if (acc_q != '0) acc_q <= acc_q - 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign acc_o = acc_q;

  assert_no_tick_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(acc_q));
  assert_sat_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && charge_i && acc_q == ACC_MAX |=> acc_q == ACC_MAX);
  assert_charge_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && charge_i && ({1'b0, acc_q} + STEP_X <= {1'b0, ACC_MAX})
    |=> acc_q == $past(acc_q) + STEP_X[ACC_W-1:0]);
  assert_no_rise_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !charge_i |=> acc_q <= $past(acc_q));
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
  import hiccup_pkg::*;
#(
  parameter int ACC_W   = 10,
  parameter int TH_RST  = 48,
  parameter int TH_FMAX = 320,
  parameter int TH_STOP = 560
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oc_i,
  input  logic             rel_i,
  input  logic             uv_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             charge_o,
  output logic             stop_rate_o,
  output logic             ss_dis_o,
  output logic             force_max_o,
  output logic             stop_o,
  output logic             pfc_stop_o
);
  localparam logic [ACC_W-1:0] RST_L  = ACC_W'(TH_RST);
  localparam logic [ACC_W-1:0] FMAX_L = ACC_W'(TH_FMAX);
  localparam logic [ACC_W-1:0] STOP_L = ACC_W'(TH_STOP);

  phase_e phase_q, phase_d;
  logic   hold_q;

  always_comb begin
    phase_d = phase_q;
    if (uv_i) begin
      phase_d = (acc_i >= RST_L) ? PH_STOP : PH_NORMAL;
    end else begin
      unique case (phase_q)
        PH_NORMAL: begin
          if (acc_i >= STOP_L)      phase_d = PH_STOP;
          else if (acc_i >= FMAX_L) phase_d = PH_FORCE;
        end
        PH_FORCE:   if (acc_i >= STOP_L) phase_d = PH_STOP;
        PH_STOP:    if (acc_i < RST_L)   phase_d = PH_RESTART;
        PH_RESTART: phase_d = PH_NORMAL;
        default:    phase_d = PH_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_NORMAL;
      hold_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (oc_i)       hold_q <= 1'b1;
      else if (rel_i) hold_q <= 1'b0;
    end
  end

  assign charge_o    = !uv_i && ((phase_q == PH_NORMAL && oc_i) || phase_q == PH_FORCE);
  assign stop_rate_o = (phase_q == PH_STOP);
  assign force_max_o = (phase_q == PH_FORCE) && !uv_i;
  assign stop_o      = (phase_q == PH_STOP) || uv_i;
  assign pfc_stop_o  = (phase_q == PH_FORCE || phase_q == PH_STOP) && !uv_i;
  assign ss_dis_o    = oc_i || hold_q || uv_i || (phase_q != PH_NORMAL);

  assert_force_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(force_max_o) && !$past(uv_i) |-> $past(acc_i) >= FMAX_L);
  assert_force_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_max_o |=> force_max_o || stop_o);
  assert_stop_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) && !uv_i && !$past(uv_i) |-> $past(acc_i) >= STOP_L);
  assert_restart_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_o) && !$past(uv_i) |-> $past(acc_i) < RST_L);
  assert_pfc_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfc_stop_o |=> pfc_stop_o || uv_i || ($past(acc_i) < RST_L));
endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor #(
  parameter int ACC_W     = 10,
  parameter int UNIT      = 16,
  parameter int CHG_STEP  = 4,
  parameter int DECAY_DIV = 64,
  parameter int STOP_DIV  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic oc_i,
  input  logic oc_rel_i,
  input  logic uv_i,
  output logic ss_dis_o,
  output logic force_max_o,
  output logic stop_o,
  output logic pfc_stop_o
);
  // thresholds keep the 0.3 : 2 : 3.5 ratio
  localparam int TH_RST  = 3 * UNIT;
  localparam int TH_FMAX = 20 * UNIT;
  localparam int TH_STOP = 35 * UNIT;

  logic [ACC_W-1:0] acc;
  logic             charge;
  logic             stop_rate;

  hiccup_acc #(
    .ACC_W(ACC_W), .CHG_STEP(CHG_STEP), .DECAY_DIV(DECAY_DIV), .STOP_DIV(STOP_DIV)
  ) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .charge_i(charge), .stop_rate_i(stop_rate), .acc_o(acc)
  );

  hiccup_seq #(
    .ACC_W(ACC_W), .TH_RST(TH_RST), .TH_FMAX(TH_FMAX), .TH_STOP(TH_STOP)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .oc_i(oc_i), .rel_i(oc_rel_i), .uv_i(uv_i),
    .acc_i(acc), .charge_o(charge), .stop_rate_o(stop_rate),
    .ss_dis_o(ss_dis_o), .force_max_o(force_max_o), .stop_o(stop_o),
    .pfc_stop_o(pfc_stop_o)
  );
endmodule

// File: tb/tb_hiccup_supervisor.sv
module tb_hiccup_supervisor;
  // small config: TH_RST=6, TH_FMAX=40, TH_STOP=70, step 2, decay /16, stop decay /2
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b1, oc = 1'b0, rel = 1'b0, uv = 1'b0;
  logic ss_dis, force_max, stop, pfc_stop;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  hiccup_supervisor #(
    .ACC_W(8), .UNIT(2), .CHG_STEP(2), .DECAY_DIV(16), .STOP_DIV(2)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .oc_i(oc), .oc_rel_i(rel),
    .uv_i(uv), .ss_dis_o(ss_dis), .force_max_o(force_max), .stop_o(stop),
    .pfc_stop_o(pfc_stop)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    // R1 reset state
    chk("R1", "ss_dis", ss_dis, 0);
    chk("R1", "force_max", force_max, 0);
    chk("R1", "stop", stop, 0);
    chk("R1", "pfc_stop", pfc_stop, 0);

    // R2: no tick, no charge; ss_dis follows oc
    tick = 1'b0; oc = 1'b1;
    step(30);
    chk("R2", "force_max without tick", force_max, 0);
    chk("R2", "ss_dis with oc", ss_dis, 1);
    oc = 1'b0; rel = 1'b1; tick = 1'b1;
    step(1);
    chk("R3", "ss_dis after release", ss_dis, 0);

    // R3: short overload, acc -> 10
    oc = 1'b1; rel = 1'b0;
    step(5);
    oc = 1'b0;
    step(3);
    chk("R3", "ss_dis held without release", ss_dis, 1);
    rel = 1'b1;
    step(1);
    chk("R3", "ss_dis cleared by release", ss_dis, 0);
    step(60); // 64 idle ticks: acc 10 -> 6

    // R4/R10: from 6 need 17 ticks to reach 40, force after edge 18
    oc = 1'b1;
    step(17);
    chk("R10", "force_max edge 17", force_max, 0);
    step(1);
    chk("R4", "force_max edge 18 (decay + residual)", force_max, 1);
    chk("R8", "pfc_stop in force", pfc_stop, 1);
    chk("R5", "ss_dis in force", ss_dis, 1);
    step(2);
    oc = 1'b0;
    step(12); // edge 32
    chk("R5", "force held without oc", force_max, 1);
    chk("R5", "stop edge 32", stop, 0);
    step(1);  // edge 33
    chk("R6", "stop edge 33", stop, 1);
    chk("R6", "force off in stop", force_max, 0);
    chk("R8", "pfc_stop in stop", pfc_stop, 1);
    chk("R6", "ss_dis in stop", ss_dis, 1);

    step(40); // edge 73
    uv = 1'b1;
    step(10);
    chk("R9", "stop during uv", stop, 1);
    chk("R9", "pfc_stop open during uv", pfc_stop, 0);
    chk("R9", "ss_dis during uv", ss_dis, 1);
    chk("R9", "force during uv", force_max, 0);
    uv = 1'b0;
    step(1);  // edge 84
    chk("R9", "stop after uv", stop, 1);
    chk("R9", "pfc_stop after uv", pfc_stop, 1);
    oc = 1'b1; rel = 1'b0;
    step(4);  // edge 88, oc ignored in stop
    oc = 1'b0; rel = 1'b1;
    step(79); // edge 167, acc 5 now
    chk("R7", "stop edge 167", stop, 1);
    step(1);
    chk("R7", "stop edge 168", stop, 0);
    chk("R7", "ss_dis in restart", ss_dis, 1);
    chk("R8", "pfc_stop in restart", pfc_stop, 0);
    chk("R6", "force in restart", force_max, 0);
    step(1);
    chk("R7", "ss_dis back in normal", ss_dis, 0);

    // R4 floor at zero, then uv during force
    step(200);
    oc = 1'b1;
    step(20);
    chk("R4", "force edge 20 from zero", force_max, 0);
    step(1);
    chk("R4", "force edge 21 from zero", force_max, 1);
    uv = 1'b1; oc = 1'b0;
    step(5);
    chk("R9", "stop in uv from force", stop, 1);
    chk("R9", "pfc_stop in uv from force", pfc_stop, 0);
    chk("R9", "force in uv", force_max, 0);
    uv = 1'b0;
    step(1);  // edge 27
    chk("R9", "stopped after uv recovery", stop, 1);
    chk("R9", "pfc_stop after uv recovery", pfc_stop, 1);
    step(68); // edge 95
    chk("R9", "stop edge 95", stop, 1);
    step(1);
    chk("R9", "restart edge 96", stop, 0);
    chk("R7", "ss_dis restart edge 96", ss_dis, 1);
    step(1);

    // uv in normal with low accumulator
    uv = 1'b1;
    #1;
    chk("R9", "stop with uv in normal", stop, 1);
    chk("R9", "ss_dis with uv in normal", ss_dis, 1);
    chk("R9", "pfc_stop with uv in normal", pfc_stop, 0);
    step(2);
    uv = 1'b0;
    #1;
    chk("R9", "stop after uv in normal", stop, 0);
    chk("R9", "ss_dis after uv in normal", ss_dis, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule